// File: doc/BRIEF.md
# Branch Target Lookup Table

This block is a small fully associative table for an instruction fetch stage. Each slot pairs an instruction address (the key) with a branch target address and a 2-bit prediction field. Every cycle the current fetch address is compared against all valid keys. One cycle later the block reports a hit flag, the stored target and the upper bit of the prediction field. On a miss all three outputs read zero.

A single write port fills the table. When the written key is already present, that slot's target and prediction field are rewritten in place. When the key is new, it goes into the slot selected by a circular replacement pointer. That pointer then moves on by one, wrapping after the last slot. Once the table is full, the oldest inserted entry is evicted first. How prediction counters evolve beyond a direct write is outside this block's scope.

Top module: `branch_target_table`

## Requirements
- R1: After reset every slot is invalid and the replacement pointer is slot 0. Every lookup therefore misses until a write occurs, and hit, target and taken read 0.
- R2: When the fetch address equals a valid stored key, the next cycle shows hit=1 and target equal to that slot's stored target.
- R3: When no valid key equals the fetch address, the next cycle shows hit=0, target=0 and taken=0.
- R4: A write with a key absent from the table stores key, target and prediction in the slot at the replacement pointer and marks it valid. The pointer then advances by one modulo DEPTH (16 by default). With the table full, the next new key evicts the earliest inserted surviving entry.
- R5: A write whose key matches a valid entry replaces that entry's target and prediction field, allocates no slot and leaves the replacement pointer where it was.
- R6: Lookup results are registered. A lookup in the same cycle as a write sees the table as it was before that write, and the write becomes visible to lookups in the following cycle.
- R7: The taken output is bit 1 of the 2-bit prediction field of the matching slot. Bit 0 never reaches the output, so a field of 2'b01 gives taken=0 with hit=1.
- R8: If more than one slot matches, the highest-indexed slot is chosen, for lookups and for update writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | ADDR_W | Address looked up this cycle |
| wr_en | input | 1 | Write strobe for insert or update |
| wr_key | input | ADDR_W | Instruction address to store or update |
| wr_target | input | ADDR_W | Branch target to store |
| wr_pred | input | 2 | Prediction field to store |
| hit | output | 1 | Registered: last lookup found a valid key |
| target | output | ADDR_W | Registered target, zero on a miss |
| taken | output | 1 | Registered upper prediction bit, zero on a miss |

## Verification
Two functions can act in the same cycle: a lookup and a write that involve the same address. The bench provokes this in two ways. It inserts a fresh key while fetching that same key, and it updates an existing key while fetching it. In each case the result must reflect the table before the write, and a repeat lookup one cycle later must reflect the write. The bench judges each result against its own model of the table, which applies the write only after it has computed the expected lookup.

// File: rtl/branch_target_table.sv
module branch_target_table #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_key,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [1:0]        wr_pred,
  output logic              hit,
  output logic [ADDR_W-1:0] target,
  output logic              taken
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] key_q  [DEPTH];
  logic [ADDR_W-1:0] tgt_q  [DEPTH];
  logic [1:0]        pred_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [PTR_W-1:0]  ptr_q;

  logic [DEPTH-1:0]  lk_vec, wr_vec;
  logic              lk_any, wr_any;
  logic [PTR_W-1:0]  lk_idx, wr_idx;

  // Ascending scan, last match kept: the highest index wins (R8).
  always_comb begin
    lk_any = 1'b0;
    wr_any = 1'b0;
    lk_idx = '0;
    wr_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      lk_vec[i] = valid_q[i] && (key_q[i] == fetch_addr);
      wr_vec[i] = valid_q[i] && (key_q[i] == wr_key);
      if (lk_vec[i]) begin
        lk_any = 1'b1;
        lk_idx = PTR_W'(i);
      end
      if (wr_vec[i]) begin
        wr_any = 1'b1;
        wr_idx = PTR_W'(i);
      end
    end
  end

  wire [PTR_W-1:0] slot = wr_any ? wr_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (wr_en) begin
      key_q[slot]   <= wr_key;
      tgt_q[slot]   <= wr_target;
      pred_q[slot]  <= wr_pred;
      valid_q[slot] <= 1'b1;
      if (!wr_any) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit    <= 1'b0;
      target <= '0;
      taken  <= 1'b0;
    end else begin
      hit    <= lk_any;
      target <= lk_any ? tgt_q[lk_idx] : '0;
      taken  <= lk_any & pred_q[lk_idx][1];
    end
  end

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (target == '0 && !taken));

  assert_taken_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> hit);

  assert_unique_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec) && $onehot0(wr_vec));

  assert_ptr_hold_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_any) |=> $stable(ptr_q));

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_any && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_any && ptr_q == LAST) |=> ptr_q == '0);

  assert_hit_tracks_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lk_vec) |=> hit);
endmodule

// File: tb/test_branch_target_table.sv
module test_branch_target_table;
  localparam int AW = 32;
  localparam int N  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_key = '0, wr_target = '0;
  logic [1:0]    wr_pred = '0;
  logic          hit, taken;
  logic [AW-1:0] target;

  always #2 clk = ~clk;

  branch_target_table #(.ADDR_W(AW), .DEPTH(N)) i_branch_target_table (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .wr_en(wr_en),
    .wr_key(wr_key), .wr_target(wr_target), .wr_pred(wr_pred),
    .hit(hit), .target(target), .taken(taken));

  int checks = 0, fails = 0;

  logic [AW-1:0] m_key [N];
  logic [AW-1:0] m_tgt [N];
  logic [1:0]    m_pred [N];
  logic [N-1:0]  m_val = '0;
  int            m_ptr = 0;

  function automatic logic [AW-1:0] tgt_of(logic [AW-1:0] k, int salt);
    return k * 3 + 32'h7 + salt;
  endfunction

  task automatic check(string req, logic [AW-1:0] addr);
    logic eh, et; logic [AW-1:0] etg;
    eh = 0; et = 0; etg = '0;
    for (int i = 0; i < N; i++)
      if (m_val[i] && m_key[i] == addr) begin
        eh = 1; etg = m_tgt[i]; et = m_pred[i][1];
      end
    checks++;
    if (hit !== eh || target !== etg || taken !== et) begin
      fails++;
      $display("FAIL %s addr=%h: got hit=%b target=%h taken=%b, expected hit=%b target=%h taken=%b",
               req, addr, hit, target, taken, eh, etg, et);
    end
  endtask

  task automatic model_write(logic [AW-1:0] k, logic [AW-1:0] t, logic [1:0] p);
    int s; s = -1;
    for (int i = 0; i < N; i++) if (m_val[i] && m_key[i] == k) s = i;
    if (s < 0) begin s = m_ptr; m_ptr = (m_ptr + 1) % N; end
    m_key[s] = k; m_tgt[s] = t; m_pred[s] = p; m_val[s] = 1'b1;
  endtask

  // One cycle: drive lookup (and optional write), check registered result
  // against the pre-write model, then apply the write to the model (R6).
  task automatic step(string req, logic [AW-1:0] la, logic we,
                      logic [AW-1:0] k, logic [AW-1:0] t, logic [1:0] p);
    fetch_addr = la; wr_en = we; wr_key = k; wr_target = t; wr_pred = p;
    @(posedge clk);
    @(negedge clk);
    check(req, la);
    if (we) model_write(k, t, p);
    wr_en = 1'b0;
  endtask

  task automatic look(string req, logic [AW-1:0] la);
    step(req, la, 1'b0, '0, '0, 2'b00);
  endtask

  task automatic put(logic [AW-1:0] k, logic [AW-1:0] t, logic [1:0] p);
    step("R4", 32'hFFFF_0000, 1'b1, k, t, p);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", '0);
    look("R1", 32'h0);
    look("R3", 32'h1000);

    // Fill all slots, every prediction code used (R4, R7)
    for (int i = 0; i < N; i++) put(32'h1000 + i*4, tgt_of(32'h1000 + i*4, 0), 2'(i));
    for (int i = 0; i < N; i++) look("R2", 32'h1000 + i*4);
    for (int i = 0; i < N; i++) look("R7", 32'h1000 + i*4);
    for (int i = 0; i < 8; i++) look("R3", 32'h2000 + i*4);
    look("R3", 32'h1002);

    // Update in place, pointer untouched (R5)
    put(32'h1014, 32'hABCD_0001, 2'b10);
    look("R5", 32'h1014);
    // New key evicts slot 0 (oldest), not the updated one (R4/R5)
    put(32'h3000, 32'h3333_0000, 2'b11);
    look("R4", 32'h1000);
    look("R4", 32'h3000);
    look("R5", 32'h1014);
    look("R4", 32'h1004);

    // Same-cycle lookup of a key being inserted (R6)
    step("R6", 32'h3100, 1'b1, 32'h3100, 32'h3100_0042, 2'b10);
    look("R6", 32'h3100);
    look("R4", 32'h1004);
    // Same-cycle lookup of a key being updated (R6)
    step("R6", 32'h3100, 1'b1, 32'h3100, 32'h0000_0099, 2'b01);
    look("R6", 32'h3100);
    look("R7", 32'h3100);

    // Full wrap: 16 more new keys displace everything
    for (int i = 0; i < N; i++) put(32'h8000 + i*8, tgt_of(32'h8000 + i*8, 5), 2'(3 - i % 4));
    for (int i = 0; i < N; i++) look("R4", 32'h1000 + i*4);
    for (int i = 0; i < N; i++) look("R2", 32'h8000 + i*8);
    look("R4", 32'h3000);
    look("R4", 32'h3100);

    // Reset again clears everything (R1)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_val = '0; m_ptr = 0;
    check("R1", '0);
    look("R1", 32'h8000);
    put(32'h9000, 32'h9, 2'b11);
    look("R1", 32'h9000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule